// File: doc/BRIEF.md
# Clock Synthesizer Reprogramming Sequencer

This block sits on the host side of an external programmable clock synthesizer. It rewrites one output channel of that synthesizer safely. The caller presents a 22-bit programming word and a one-cycle start pulse. The sequencer then works through four steps:

1. It lowers the channel's clock-select line, so the channel falls back to its reference clock, and holds it low for a setup interval.
2. It shifts the word out on a serial data line and a serial clock line.
3. It waits a long settling interval while the synthesizer's loop locks.
4. It raises the select line again, handing the channel back to the newly programmed clock.

A one-cycle completion pulse marks the end of the sequence. Because of this framing, logic downstream never runs on a channel whose loop has not yet locked.

All intervals are counted in system clock cycles and set by parameters, and a single shared down-counter times them. The serial clock half-period must be chosen so that each high phase and each low phase lasts at least one reference period of the synthesizer. Choose the setup interval to cover at least one period of the old output frequency. Choose the settle interval to cover the lock time, which can be up to 10 ms.

Top module: `clk_prog_seq`

## Requirements
- R1: While reset is asserted and immediately after it, the select line is high, the serial clock is low, and both busy and done are low.
- R2: A start pulse seen while the block is idle makes the select line go low and busy go high on the next cycle.
- R3: The first rising serial clock edge comes exactly SETUP_CYC + HALF_CYC cycles after the select line fell, and the select line stays low throughout the transfer.
- R4: Each word produces exactly WORD_W (22) rising serial clock edges.
- R5: Inside the transfer, every serial clock low phase and every high phase lasts exactly HALF_CYC cycles.
- R6: The serial data line changes only while the serial clock is low, that is, after a falling edge. It never changes in a cycle where the serial clock is high, including the cycle in which it rises.
- R7: Bits are sent most significant bit first when MSB_FIRST = 1, which is the default. The value sampled on rising edge k is word bit WORD_W-1-k.
- R8: The select line returns high exactly SETTLE_CYC cycles after the final falling serial clock edge.
- R9: Done is high for exactly one cycle, and that cycle is the one after the select line returns high.
- R10: A start pulse arriving while busy is ignored. The word in flight and its timing are unchanged, and no second sequence follows.
- R11: The serial clock is low whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program the channel |
| word_i | input | WORD_W | Programming word, captured when start is accepted |
| ref_sel_o | output | 1 | Channel select: 0 = reference clock, 1 = programmed clock |
| ser_clk_o | output | 1 | Serial clock to the synthesizer |
| ser_dat_o | output | 1 | Serial data to the synthesizer |
| busy_o | output | 1 | High from start acceptance until return to idle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench measures every phase length against the parameters. A design that counted one cycle too many or too few in the setup, half-period or settle wait would move the first rising edge or the select release off its expected cycle. A 21- or 23-pulse transfer, or a reversed bit order, would show up as a wrong captured word, and the test words are chosen with asymmetric and alternating patterns so that such errors cannot cancel out. A data change on the rising clock edge would be flagged as a setup/hold violation. A start pulse injected in the middle of a transfer would, in a design that restarts, corrupt the captured word and produce a second completion pulse.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL_LOW,
      ST_SHIFT,
      ST_SETTLE,
      ST_SEL_HIGH,
      ST_DONE
   } seq_state_e;

   // Bits needed to hold (max interval - 1), at least one.
   function automatic int unsigned wait_cnt_bits(input int unsigned a,
                                                 input int unsigned b,
                                                 input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load)     cnt_q <= load_val;
      else if (!zero)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // The controller only reloads an expired interval (R5).
   assert_load_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> zero);

endmodule

// File: rtl/clkseq_shifter.sv
module clkseq_shifter #(
   parameter int unsigned WORD_W    = 22,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              shift,
   output logic              bit_out,
   output logic              last
);
   localparam int unsigned BIT_W = (WORD_W <= 2) ? 1 : $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sreg_q;
   logic [BIT_W-1:0]  idx_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sreg_q <= '0;
            else if (load)  sreg_q <= word;
            else if (shift) sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
         end
         assign bit_out = sreg_q[WORD_W-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sreg_q <= '0;
            else if (load)  sreg_q <= word;
            else if (shift) sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
         end
         assign bit_out = sreg_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (load)  idx_q <= '0;
      else if (shift) idx_q <= idx_q + 1'b1;
   end

   assign last = (idx_q == LAST_IDX);

   // No advance beyond the final bit of the word (R4).
   assert_no_shift_past_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !last);

endmodule

// File: rtl/clk_prog_seq.sv
module clk_prog_seq
   import clkseq_pkg::*;
#(
   parameter int unsigned WORD_W     = 22,
   parameter int unsigned SETUP_CYC  = 64,
   parameter int unsigned HALF_CYC   = 4,
   parameter int unsigned SETTLE_CYC = 1_000_000,
   parameter bit          MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              ref_sel_o,
   output logic              ser_clk_o,
   output logic              ser_dat_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = wait_cnt_bits(SETUP_CYC, HALF_CYC, SETTLE_CYC);
   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HALF_LD   = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

   if (WORD_W < 2)     begin : g_bad_word   $error("WORD_W must be at least 2");     end
   if (SETUP_CYC < 1)  begin : g_bad_setup  $error("SETUP_CYC must be at least 1");  end
   if (HALF_CYC < 1)   begin : g_bad_half   $error("HALF_CYC must be at least 1");   end
   if (SETTLE_CYC < 1) begin : g_bad_settle $error("SETTLE_CYC must be at least 1"); end

   seq_state_e       state_q, state_d;
   logic             sclk_q, sclk_d;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, sh_shift, sh_last, sh_bit;

   clkseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   clkseq_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .word    (word_i),
      .shift   (sh_shift),
      .bit_out (sh_bit),
      .last    (sh_last)
   );

   always_comb begin
      state_d  = state_q;
      sclk_d   = sclk_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_SEL_LOW;
               tmr_load = 1'b1;
               tmr_val  = SETUP_LD;
               sh_load  = 1'b1;
            end
         end
         ST_SEL_LOW: begin
            if (tmr_zero) begin
               state_d  = ST_SHIFT;
               sclk_d   = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = HALF_LD;
            end
         end
         ST_SHIFT: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (!sclk_q) begin
                  sclk_d  = 1'b1;
                  tmr_val = HALF_LD;
               end else begin
                  sclk_d = 1'b0;
                  if (sh_last) begin
                     state_d = ST_SETTLE;
                     tmr_val = SETTLE_LD;
                  end else begin
                     sh_shift = 1'b1;
                     tmr_val  = HALF_LD;
                  end
               end
            end
         end
         ST_SETTLE:   if (tmr_zero) state_d = ST_SEL_HIGH;
         ST_SEL_HIGH: state_d = ST_DONE;
         ST_DONE:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sclk_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         sclk_q  <= sclk_d;
      end
   end

   assign ref_sel_o = (state_q == ST_IDLE) || (state_q == ST_SEL_HIGH) || (state_q == ST_DONE);
   assign ser_clk_o = sclk_q;
   assign ser_dat_o = sh_bit;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);

   // A sequence is entered only from idle (R2, R10).
   assert_enter_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEL_LOW && $past(state_q) != ST_SEL_LOW) |-> $past(state_q) == ST_IDLE);

   // Serial clock toggles only when the shared timer has expired (R5).
   assert_sclk_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q != $past(sclk_q)) |-> $past(tmr_zero));

   // Data holds through the rising edge and the high phase (R6).
   assert_data_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(sh_bit));

   // Reference is selected whenever the serial clock rises (R3).
   assert_sel_low_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> !ref_sel_o);

   // Done is a single-cycle pulse with the programmed clock selected (R9).
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ref_sel_o);

   // Serial clock parked low outside the transfer (R11).
   assert_idle_sclk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_SHIFT) |-> !sclk_q);

endmodule

// File: tb/clk_prog_seq_bench.sv
module clk_prog_seq_bench;
   localparam int unsigned W  = 22;
   localparam int unsigned S  = 5;
   localparam int unsigned H  = 3;
   localparam int unsigned T  = 20;
   localparam int unsigned NV = 4;

   // Stimulus words; the expected captured serial word equals each entry.
   localparam logic [W-1:0] VEC [NV] = '{
      22'h3FFFFF, 22'h200001, 22'h2AAAAA, 22'h0C5A93
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [W-1:0] word_i = '0;
   logic ref_sel_o, ser_clk_o, ser_dat_o, busy_o, done_o;

   always #2.5 clk = ~clk;

   clk_prog_seq #(.WORD_W(W), .SETUP_CYC(S), .HALF_CYC(H), .SETTLE_CYC(T), .MSB_FIRST(1'b1))
   u_clk_prog_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
      .ref_sel_o(ref_sel_o), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Port monitor, sampled on the falling system clock edge.
   int cyc = 0;
   int rises, falls, phase_err, data_err, done_cnt;
   int t_sel_fall, t_first_rise, t_last_rise, t_last_fall, t_sel_rise, t_done;
   logic [W-1:0] cap;
   logic prev_sclk = 1'b0, prev_sel = 1'b1, prev_dat = 1'b0;

   task automatic clear_mon();
      rises = 0; falls = 0; phase_err = 0; data_err = 0; done_cnt = 0;
      t_sel_fall = 0; t_first_rise = 0; t_last_rise = 0; t_last_fall = 0;
      t_sel_rise = 0; t_done = 0; cap = '0;
   endtask

   initial clear_mon();

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_sel && !ref_sel_o) t_sel_fall = cyc;
         if (!prev_sel && ref_sel_o) t_sel_rise = cyc;
         if (!prev_sclk && ser_clk_o) begin
            rises++;
            cap = {cap[W-2:0], ser_dat_o};
            if (rises == 1) t_first_rise = cyc;
            else if (cyc - t_last_fall != H) phase_err++;
            t_last_rise = cyc;
         end
         if (prev_sclk && !ser_clk_o) begin
            falls++;
            if (cyc - t_last_rise != H) phase_err++;
            t_last_fall = cyc;
         end
         if (ser_clk_o && ser_dat_o != prev_dat) data_err++;
         if (done_o) begin done_cnt++; t_done = cyc; end
      end
      prev_sclk = ser_clk_o;
      prev_sel  = ref_sel_o;
      prev_dat  = ser_dat_o;
   end

   task automatic wait_done();
      for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
      repeat (3) @(posedge clk);
   endtask

   task automatic run_word(input logic [W-1:0] w);
      @(posedge clk);
      clear_mon();
      @(negedge clk);
      start_i = 1'b1; word_i = w;
      @(negedge clk);
      start_i = 1'b0;
      chk(!ref_sel_o && busy_o, "R2 select low and busy after start", {ref_sel_o, busy_o}, 2'b01);
      wait_done();
      chk(rises == W, "R4 rising edge count", rises, W);
      chk(cap == w, "R7 captured word MSB first", cap, w);
      chk(t_first_rise - t_sel_fall == S + H, "R3 select-low to first rise", t_first_rise - t_sel_fall, S + H);
      chk(phase_err == 0, "R5 half-period length errors", phase_err, 0);
      chk(data_err == 0, "R6 data changes while clock high", data_err, 0);
      chk(t_sel_rise - t_last_fall == T, "R8 settle after last fall", t_sel_rise - t_last_fall, T);
      chk(done_cnt == 1 && t_done - t_sel_rise == 1, "R9 done pulse position",
          (done_cnt << 8) | (t_done - t_sel_rise), 32'h101);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ref_sel_o && !ser_clk_o && !busy_o && !done_o, "R1 state in reset",
          {ref_sel_o, ser_clk_o, busy_o, done_o}, 4'b1000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(ref_sel_o && !ser_clk_o && !busy_o && !done_o, "R1 state after reset",
          {ref_sel_o, ser_clk_o, busy_o, done_o}, 4'b1000);
      chk(!ser_clk_o, "R11 serial clock idle low", ser_clk_o, 0);

      for (int v = 0; v < NV; v++) run_word(VEC[v]);

      // R10: start during an active transfer
      @(posedge clk);
      clear_mon();
      @(negedge clk);
      start_i = 1'b1; word_i = 22'h155555;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 500 && rises < 5; i++) @(negedge clk);
      start_i = 1'b1; word_i = 22'h0F0F0F;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      chk(cap == 22'h155555 && rises == W, "R10 word unchanged by late start", cap, 22'h155555);
      chk(t_first_rise - t_sel_fall == S + H && t_sel_rise - t_last_fall == T,
          "R10 timing unchanged by late start", t_sel_rise - t_last_fall, T);
      repeat (40) @(negedge clk);
      chk(done_cnt == 1 && !busy_o && ref_sel_o, "R10 no second sequence",
          {done_cnt[3:0], busy_o, ref_sel_o}, 6'b000101);
      chk(!ser_clk_o, "R11 serial clock low after sequence", ser_clk_o, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule